// File: doc/BRIEF.md
# Rotating-Token Four-Port Crossbar Scheduler

This block schedules a four-input, four-output packet crossbar. Each input offers the destination output of its head-of-line packet. That destination has already been resolved by a route lookup outside the block. The block works in rounds. In each round it asks for headers, takes a snapshot of all four requests, and builds one switch setting. It then routes the packet bodies through that setting and waits for the round to be confirmed before the next round starts.

Outputs are granted by a single priority token that moves from input to input, one step per confirmed round. The input that holds the token always gets the output it asked for. The remaining inputs are visited in ring order, starting just after the token holder, and each one is granted only if its output is still free. Because of this, only four visiting orders exist, one per token position, and the setting used in a round is the one that the chosen order produces. An input that is refused keeps its packet and asks again. It will hold the token itself within four rounds.

The control state machine has four states:
- `S_ASK` raises `hdr_req`. It moves to `S_PICK` when `hdr_vld` is high.
- `S_PICK` registers the switch setting. It always moves to `S_XFER`.
- `S_XFER` streams the bodies. It moves to `S_DONE` once every granted input has finished.
- `S_DONE` raises `round_done`. It moves back to `S_ASK` on `done_ack`, and the token advances on that same edge.

Top module: `rtx_sched`

## Requirements
- R1: After reset the block is in `S_ASK`: `hdr_req`=1, `token`=0, and `grant`, `sel_en`, `in_ready`, `out_valid` and `round_done` are all 0.
- R2: An input that holds the token and has `in_req` set is always granted. Its output's `sel_src` field equals the token value.
- R3: Inputs other than the token holder are visited in the order token+1, token+2, token+3 (mod 4). Each is granted only if no earlier-visited input already took its output. No output is ever granted to two inputs.
- R4: An input with `in_req`=0 is never granted, and its body signals are ignored. An output with no grant keeps `out_valid`, `out_last` and its `out_data` field at 0 for the whole round.
- R5: `hdr_req` is 1 only in `S_ASK`. The headers are captured on the edge where `hdr_req` and `hdr_vld` are both 1. `grant` is 0 after that edge and shows the new round's grants after the next edge.
- R6: While streaming, each granted output carries its source input's valid, last and data. That input's `in_ready` follows the output's `out_ready`. Inputs that are not granted see `in_ready`=0.
- R7: `round_done` rises only after every granted input has completed a beat with valid, ready and last all high. An input that has finished releases its output (`sel_en` goes low).
- R8: `token` advances by one (mod 4) only on an edge where `round_done` and `done_ack` are both 1. At every other edge it keeps its value.
- R9: `grant` holds steady from the start of streaming until the round is confirmed, and then clears to 0.
- Field encodings: `in_dest` and `sel_src` use bits [2k+1:2k] for port k. `in_data` and `out_data` use bits [8k+7:8k] for port k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_req | output | 1 | Header request (high in `S_ASK`) |
| hdr_vld | input | 1 | Headers on `in_req`/`in_dest` are valid |
| in_req | input | 4 | Per input: a head-of-line packet is waiting |
| in_dest | input | 8 | Per input: 2-bit destination output |
| grant | output | 4 | Per input: granted this round |
| token | output | 2 | Index of the input holding the token |
| sel_en | output | 4 | Per output: crossbar path enabled |
| sel_src | output | 8 | Per output: 2-bit source input |
| in_valid | input | 4 | Per input: body beat valid |
| in_last | input | 4 | Per input: last body beat |
| in_data | input | 32 | Per input: body data, 8 bits each |
| in_ready | output | 4 | Per input: beat accepted |
| out_valid | output | 4 | Per output: beat valid |
| out_last | output | 4 | Per output: last beat |
| out_data | output | 32 | Per output: body data, 8 bits each |
| out_ready | input | 4 | Per output: downstream ready |
| round_done | output | 1 | Round complete, waiting for confirmation |
| done_ack | input | 1 | Confirms the round and advances the token |

## Verification
The hardest case to reach is a round in which grants finish at different times while an output is stalled. One input's last beat has already gone through, so its output is released, while another granted input is still held by a low `out_ready` and has not yet sent its last beat. The bench reaches this with a directed round. It grants two inputs and stalls one output for a cycle. It then sends a multi-beat body on the stalled path and checks that `round_done` stays low until the final beat. The vector table walks the token through every position and includes rounds where the token holder has no request, so that the ring order alone decides which slave wins.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
    localparam int IW = 2;          // bits of a port index
    localparam int NP = 1 << IW;    // ports on each side
    localparam int DW = 8;          // body data width

    typedef logic [IW-1:0] port_t;

    typedef enum logic [1:0] {
        S_ASK,
        S_PICK,
        S_XFER,
        S_DONE
    } phase_t;
endpackage

// File: rtl/rtx_alloc.sv
// Builds one switch setting: token holder first, then ring order.
module rtx_alloc
    import rtx_pkg::*;
(
    input  port_t                  tok,
    input  logic [NP-1:0]          req,
    input  logic [NP-1:0][IW-1:0]  dest,
    output logic [NP-1:0]          gnt,
    output logic [NP-1:0]          oen,
    output logic [NP-1:0][IW-1:0]  osrc
);
    always_comb begin : visit
        port_t idx;
        gnt  = '0;
        oen  = '0;
        osrc = '0;
        idx  = '0;
        for (int k = 0; k < NP; k++) begin
            idx = tok + port_t'(k);
            if (req[idx] && !oen[dest[idx]]) begin
                gnt[idx]        = 1'b1;
                oen[dest[idx]]  = 1'b1;
                osrc[dest[idx]] = idx;
            end
        end
    end
endmodule

// File: rtl/rtx_path.sv
// Crossbar datapath: one mux per output, ready steered back per input.
module rtx_path
    import rtx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   act,
    input  logic [NP-1:0]          oen,
    input  logic [NP-1:0][IW-1:0]  osrc,
    input  logic [NP-1:0]          live,
    input  logic [NP-1:0]          in_valid,
    input  logic [NP-1:0]          in_last,
    input  logic [NP-1:0][DW-1:0]  in_data,
    output logic [NP-1:0]          in_ready,
    input  logic [NP-1:0]          out_ready,
    output logic [NP-1:0]          out_valid,
    output logic [NP-1:0]          out_last,
    output logic [NP-1:0][DW-1:0]  out_data,
    output logic [NP-1:0]          sel_en,
    output logic [NP-1:0]          fire_last
);
    for (genvar o = 0; o < NP; o++) begin : g_out
        assign sel_en[o]    = act & oen[o] & live[osrc[o]];
        assign out_valid[o] = sel_en[o] & in_valid[osrc[o]];
        assign out_last[o]  = sel_en[o] & in_last[osrc[o]];
        assign out_data[o]  = sel_en[o] ? in_data[osrc[o]] : '0;
    end

    always_comb begin
        in_ready = '0;
        for (int o = 0; o < NP; o++) begin
            if (sel_en[o] && out_ready[o])
                in_ready[osrc[o]] = 1'b1;
        end
    end

    assign fire_last = in_valid & in_ready & in_last;

    for (genvar i = 0; i < NP; i++) begin : g_chk
        assert_ready_only_live_R6 : assert property (@(posedge clk) disable iff (!rst_n)
            in_ready[i] |-> (act && live[i]));
    end
endmodule

// File: rtl/rtx_ctrl.sv
// Round sequencer: header capture, setting register, body tracking, token.
module rtx_ctrl
    import rtx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hdr_vld,
    input  logic [NP-1:0]          in_req,
    input  logic [NP-1:0][IW-1:0]  in_dest,
    input  logic                   done_ack,
    input  logic [NP-1:0]          a_gnt,
    input  logic [NP-1:0]          a_oen,
    input  logic [NP-1:0][IW-1:0]  a_osrc,
    input  logic [NP-1:0]          fire_last,
    output logic                   hdr_req,
    output logic                   round_done,
    output logic                   act,
    output port_t                  tok,
    output logic [NP-1:0]          req_q,
    output logic [NP-1:0][IW-1:0]  dest_q,
    output logic [NP-1:0]          gnt_q,
    output logic [NP-1:0]          oen_q,
    output logic [NP-1:0][IW-1:0]  osrc_q,
    output logic [NP-1:0]          live
);
    phase_t        state, nxt;
    logic [NP-1:0] done_q;
    logic          all_done;

    assign all_done = (((done_q | fire_last) & gnt_q) == gnt_q);

    always_comb begin
        nxt = state;
        unique case (state)
            S_ASK:  if (hdr_vld)  nxt = S_PICK;
            S_PICK:               nxt = S_XFER;
            S_XFER: if (all_done) nxt = S_DONE;
            S_DONE: if (done_ack) nxt = S_ASK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_ASK;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok    <= '0;
            req_q  <= '0;
            dest_q <= '0;
            gnt_q  <= '0;
            oen_q  <= '0;
            osrc_q <= '0;
            done_q <= '0;
        end else begin
            unique case (state)
                S_ASK: if (hdr_vld) begin
                    req_q  <= in_req;
                    dest_q <= in_dest;
                end
                S_PICK: begin
                    gnt_q  <= a_gnt;
                    oen_q  <= a_oen;
                    osrc_q <= a_osrc;
                    done_q <= '0;
                end
                S_XFER: done_q <= done_q | (fire_last & gnt_q);
                S_DONE: if (done_ack) begin
                    tok    <= tok + 1'b1;
                    gnt_q  <= '0;
                    oen_q  <= '0;
                    osrc_q <= '0;
                end
            endcase
        end
    end

    always_comb begin
        hdr_req    = (state == S_ASK);
        act        = (state == S_XFER);
        round_done = (state == S_DONE);
        live       = gnt_q & ~done_q;
    end

    assert_master_wins_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PICK && req_q[tok]) |=> (gnt_q[tok] && osrc_q[dest_q[tok]] == tok));

    assert_token_step_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (round_done && done_ack) |=> (tok == port_t'($past(tok) + 1'b1)));

    assert_token_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        !(round_done && done_ack) |=> $stable(tok));

    assert_grant_steady_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        act |=> $stable(gnt_q));

    assert_hdr_once_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_req && hdr_vld) |=> (!hdr_req && gnt_q == '0));

    assert_no_unrequested_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        act |-> ((gnt_q & ~req_q) == '0));
endmodule

// File: rtl/rtx_sched.sv
module rtx_sched
    import rtx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    output logic               hdr_req,
    input  logic               hdr_vld,
    input  logic [NP-1:0]      in_req,
    input  logic [NP*IW-1:0]   in_dest,
    output logic [NP-1:0]      grant,
    output logic [IW-1:0]      token,
    output logic [NP-1:0]      sel_en,
    output logic [NP*IW-1:0]   sel_src,
    input  logic [NP-1:0]      in_valid,
    input  logic [NP-1:0]      in_last,
    input  logic [NP*DW-1:0]   in_data,
    output logic [NP-1:0]      in_ready,
    output logic [NP-1:0]      out_valid,
    output logic [NP-1:0]      out_last,
    output logic [NP*DW-1:0]   out_data,
    input  logic [NP-1:0]      out_ready,
    output logic               round_done,
    input  logic               done_ack
);
    logic                   act;
    port_t                  tok;
    logic [NP-1:0]          req_q, gnt_q, oen_q, live, fire_last;
    logic [NP-1:0]          a_gnt, a_oen;
    logic [NP-1:0][IW-1:0]  dest_q, osrc_q, a_osrc, dest_in;
    logic [NP-1:0][DW-1:0]  din, dout;

    assign dest_in  = in_dest;
    assign din      = in_data;
    assign out_data = dout;
    assign grant    = gnt_q;
    assign token    = tok;
    assign sel_src  = osrc_q;

    rtx_alloc u_alloc (
        .tok  (tok),
        .req  (req_q),
        .dest (dest_q),
        .gnt  (a_gnt),
        .oen  (a_oen),
        .osrc (a_osrc)
    );

    rtx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hdr_vld    (hdr_vld),
        .in_req     (in_req),
        .in_dest    (dest_in),
        .done_ack   (done_ack),
        .a_gnt      (a_gnt),
        .a_oen      (a_oen),
        .a_osrc     (a_osrc),
        .fire_last  (fire_last),
        .hdr_req    (hdr_req),
        .round_done (round_done),
        .act        (act),
        .tok        (tok),
        .req_q      (req_q),
        .dest_q     (dest_q),
        .gnt_q      (gnt_q),
        .oen_q      (oen_q),
        .osrc_q     (osrc_q),
        .live       (live)
    );

    rtx_path u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .oen       (oen_q),
        .osrc      (osrc_q),
        .live      (live),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_data   (din),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_data  (dout),
        .sel_en    (sel_en),
        .fire_last (fire_last)
    );

    for (genvar o = 0; o < NP; o++) begin : g_col
        logic [NP-1:0] col;
        always_comb begin
            for (int i = 0; i < NP; i++)
                col[i] = gnt_q[i] && (dest_q[i] == port_t'(o));
        end
        assert_single_source_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            act |-> $onehot0(col));
    end
endmodule

// File: tb/rtx_sched_test.sv
`timescale 1ns/1ps
module rtx_sched_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        hdr_req, hdr_vld;
    logic [3:0]  in_req, grant, sel_en, in_valid, in_last, in_ready;
    logic [3:0]  out_valid, out_last, out_ready;
    logic [7:0]  in_dest, sel_src;
    logic [1:0]  token;
    logic [31:0] in_data, out_data;
    logic        round_done, done_ack;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    rtx_sched uut (
        .clk(clk), .rst_n(rst_n), .hdr_req(hdr_req), .hdr_vld(hdr_vld),
        .in_req(in_req), .in_dest(in_dest), .grant(grant), .token(token),
        .sel_en(sel_en), .sel_src(sel_src), .in_valid(in_valid),
        .in_last(in_last), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_last(out_last), .out_data(out_data),
        .out_ready(out_ready), .round_done(round_done), .done_ack(done_ack)
    );

    // {request[3:0], destinations[7:0], expected grant[3:0]}; token = row mod 4
    localparam logic [15:0] VEC [0:6] = '{
        16'hF1AD, 16'hFFF2, 16'h5154, 16'h7305,
        16'h0000, 16'hF93F, 16'hB82A
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic do_round(input logic [3:0] rq, input logic [7:0] ds,
                            input logic [3:0] eg, input logic [1:0] et);
        chk(hdr_req == 1'b1, "R5 hdr_req in ask", int'(hdr_req), 1);
        chk(token == et, "R8 token at round start", int'(token), int'(et));
        in_req = rq; in_dest = ds; hdr_vld = 1'b1;
        @(negedge clk);
        hdr_vld = 1'b0;
        chk(hdr_req == 1'b0 && grant == 4'h0, "R5 pick phase", int'({hdr_req, grant}), 0);
        @(negedge clk);
        chk(grant == eg, "R2 R3 grant", int'(grant), int'(eg));
        in_valid = 4'hF; in_last = 4'hF; in_data = 32'hA3A2A1A0; out_ready = 4'hF;
        #1;
        for (int o = 0; o < 4; o++) begin
            int src;
            src = -1;
            for (int i = 0; i < 4; i++)
                if (eg[i] && ds[2*i +: 2] == o[1:0]) src = i;
            if (src >= 0) begin
                chk(out_valid[o] && out_last[o], "R6 path valid/last", int'({out_valid[o], out_last[o]}), 3);
                chk(out_data[8*o +: 8] == 8'hA0 + src[7:0], "R6 path data", int'(out_data[8*o +: 8]), 8'hA0 + src);
                chk(sel_src[2*o +: 2] == src[1:0], "R2 sel_src", int'(sel_src[2*o +: 2]), src);
            end else begin
                chk(!out_valid[o] && !out_last[o] && out_data[8*o +: 8] == 8'h00,
                    "R4 idle output", int'({out_valid[o], out_last[o], out_data[8*o +: 8]}), 0);
            end
        end
        chk(in_ready == eg, "R6 R4 in_ready", int'(in_ready), int'(eg));
        @(negedge clk);
        in_valid = 4'h0; in_last = 4'h0;
        chk(round_done == 1'b1, "R7 round_done after last", int'(round_done), 1);
        @(negedge clk);
        chk(round_done == 1'b1 && token == et, "R8 token waits for ack", int'(token), int'(et));
        chk(grant == eg, "R9 grant held until ack", int'(grant), int'(eg));
        done_ack = 1'b1;
        @(negedge clk);
        done_ack = 1'b0;
        chk(grant == 4'h0, "R9 grant cleared", int'(grant), 0);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; hdr_vld = 1'b0; in_req = '0; in_dest = '0;
        in_valid = '0; in_last = '0; in_data = '0; out_ready = '0; done_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hdr_req == 1'b1 && token == 2'd0, "R1 reset ask/token", int'({hdr_req, token}), 4);
        chk(grant == 4'h0 && sel_en == 4'h0 && in_ready == 4'h0, "R1 reset grants",
            int'({grant, sel_en, in_ready}), 0);
        chk(out_valid == 4'h0 && round_done == 1'b0, "R1 reset outputs",
            int'({out_valid, round_done}), 0);

        for (int r = 0; r < 7; r++)
            do_round(VEC[r][15:12], VEC[r][11:4], VEC[r][3:0], r[1:0]);

        // Directed: token 3, in3->2 (master), in0->1; stalled output and multi-beat body
        chk(token == 2'd3, "R8 token after seven rounds", int'(token), 3);
        in_req = 4'b1001; in_dest = 8'h81; hdr_vld = 1'b1;
        @(negedge clk);
        hdr_vld = 1'b0;
        @(negedge clk);
        chk(grant == 4'b1001, "R2 R3 directed grant", int'(grant), 9);
        out_ready = 4'b1011; in_valid = 4'b1001; in_last = 4'b0001; in_data = 32'hA3A2A1A0;
        #1;
        chk(in_ready == 4'b0001, "R6 stalled output holds input", int'(in_ready), 1);
        chk(out_valid[2] && !out_last[2], "R6 stalled path shows beat", int'({out_valid[2], out_last[2]}), 2);
        @(negedge clk);
        chk(round_done == 1'b0, "R7 waits on unfinished input", int'(round_done), 0);
        chk(sel_en == 4'b0100, "R7 finished input releases output", int'(sel_en), 4);
        out_ready = 4'hF; in_valid = 4'b1000; in_last = 4'b0000;
        @(negedge clk);
        chk(round_done == 1'b0, "R7 non-last beat keeps round open", int'(round_done), 0);
        in_last = 4'b1000;
        @(negedge clk);
        in_valid = 4'h0; in_last = 4'h0;
        chk(round_done == 1'b1, "R7 round ends after final last", int'(round_done), 1);
        @(negedge clk);
        chk(token == 2'd3, "R8 token holds without ack", int'(token), 3);
        done_ack = 1'b1;
        @(negedge clk);
        done_ack = 1'b0;
        chk(token == 2'd0 && hdr_req == 1'b1, "R8 token wraps to 0", int'({hdr_req, token}), 4);

        finish_run();
    end
endmodule